// File: doc/BRIEF.md
# Masked Multi-Port Memory with Scheduled Latencies

This block is a synchronous word memory with three access points on one clock. There is a read-only port, a write-only port and a combined port that can either read or write on a given cycle. Each stored word is split into `LANES` lanes of `LANE_W` bits. Both writing ports carry a lane mask, so a write can replace part of a word. Every request passes through a register pipeline, which delivers it to the storage array on a fixed, parameter-chosen cycle. Read latency, write latency and the policy for a read and a write that meet at one word are all set at build time.

The read-under-write policy picks the pipeline position at which the read-only port samples the array. With the old-data policy the array is sampled as the request arrives and the word then travels through data registers. With the new-data policy the address travels first and the array is sampled at the last moment. With the undefined policy the array is sampled halfway between. The combined port works at one latency `L` (equal to `READ_LATENCY`), and reads and writes at the last pipeline position. It can be left out with `USE_RW = 0`. When it is present, elaboration stops if `READ_LATENCY` differs from `WRITE_LATENCY` or if the old-data policy is chosen. Elaboration also stops if `WRITE_LATENCY` is below one.

The ports use plain enables rather than a valid/ready handshake. The array accepts one request per port on every cycle, so the block never applies back-pressure.

Top module: `masked_mem_ports`

## Requirements
- R1: While `rst_n` is low, and after release until the first request reaches an output, `rd_data` and `rw_rdata` are zero.
- R2: A write-port request in cycle n changes the stored word at the clock edge that ends cycle n+WRITE_LATENCY. A sample of the array taken in cycle n+WRITE_LATENCY+1 or later sees the new value; an earlier sample sees the old value.
- R3: Mask bit i selects data bits [i*LANE_W +: LANE_W]. A lane whose mask bit is 0 keeps its stored value.
- R4: A read-port request in cycle n is answered on `rd_data` during cycle n+READ_LATENCY. If `rd_en` was low in cycle n, `rd_data` is zero in that cycle.
- R5: The word returned for a read in cycle n is the array content during cycle n+S. S is 0 for the old-data policy, READ_LATENCY for new-data, and floor(READ_LATENCY/2) for undefined.
- R6: Suppose `rw_en` is high and `rw_write` is low in cycle n. Then `rw_rdata` during cycle n+L equals the array content in that same cycle. In every other case `rw_rdata` is zero in cycle n+L.
- R7: A combined-port request with both `rw_en` and `rw_write` high in cycle n does a masked write at the edge that ends cycle n+L, with the lane encoding of R3. A request with `rw_write` low never alters the array.
- R8: A write to an address of `DEPTH` or more, on either port, changes nothing. A read of such an address returns zero.
- R9: If both writing ports update the same word at one edge, each lane enabled in both masks takes the combined port's data.
- R10: With `USE_RW = 0`, the combined-port inputs have no effect on the array, and `rw_rdata` stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all ports |
| rst_n | input | 1 | Asynchronous active-low reset of the pipelines |
| rd_en | input | 1 | Read-port request enable |
| rd_addr | input | $clog2(DEPTH+1) | Read-port word address |
| rd_data | output | LANES*LANE_W | Read-port data, READ_LATENCY cycles after the request |
| wr_en | input | 1 | Write-port request enable |
| wr_addr | input | $clog2(DEPTH+1) | Write-port word address |
| wr_data | input | LANES*LANE_W | Write-port data |
| wr_mask | input | LANES | Write-port lane mask |
| rw_en | input | 1 | Combined-port request enable |
| rw_addr | input | $clog2(DEPTH+1) | Combined-port word address |
| rw_write | input | 1 | Combined-port mode: 1 write, 0 read |
| rw_wdata | input | LANES*LANE_W | Combined-port write data |
| rw_mask | input | LANES | Combined-port lane mask |
| rw_rdata | output | LANES*LANE_W | Combined-port read data, L cycles after the request |

## Verification
Three copies receive one shared stimulus: new-data with the combined port, old-data without it, and undefined with it. A directed sequence writes one word and then reads it on four consecutive cycles, so each policy must switch to the new value on a different cycle. Further directed steps cover a partial-mask write, two ports writing one word in the same cycle with overlapping masks, out-of-range addresses, and a combined-port write followed by reads. After that, seeded random traffic on a 16-value address space forces frequent collisions. Each output is compared with a cycle-indexed snapshot history of a reference array. The copy without the combined port tracks its own history, which shows that the combined-port inputs have no effect on it.

// File: rtl/mport_pkg.sv
package mport_pkg;

  typedef enum logic [1:0] {
    RUW_OLD   = 2'd0,
    RUW_NEW   = 2'd1,
    RUW_UNDEF = 2'd2
  } ruw_e;

  // Pipeline position at which the read-only port samples the array.
  function automatic int sample_stage(ruw_e policy, int read_lat);
    case (policy)
      RUW_OLD: return 0;
      RUW_NEW: return read_lat;
      default: return read_lat / 2;
    endcase
  endfunction

endpackage

// File: rtl/mport_delay.sv
module mport_delay #(
  parameter int W = 1,
  parameter int N = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  if (N == 0) begin : g_wire
    logic unused_clk;
    assign unused_clk = clk ^ rst_n;
    assign dout       = din;
  end else begin : g_regs
    logic [W-1:0] stg [N];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int k = 0; k < N; k++) stg[k] <= '0;
      end else begin
        stg[0] <= din;
        for (int k = 1; k < N; k++) stg[k] <= stg[k-1];
      end
    end
    assign dout = stg[N-1];
  end

endmodule

// File: rtl/mport_array.sv
module mport_array #(
  parameter int DEPTH  = 12,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int AW     = 4,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ra_en,
  input  logic [AW-1:0]    ra_addr,
  output logic [DW-1:0]    ra_data,
  input  logic             rb_en,
  input  logic [AW-1:0]    rb_addr,
  output logic [DW-1:0]    rb_data,
  input  logic             w_ok,
  input  logic [AW-1:0]    w_addr,
  input  logic [DW-1:0]    w_data,
  input  logic [LANES-1:0] w_mask,
  input  logic             v_ok,
  input  logic [AW-1:0]    v_addr,
  input  logic [DW-1:0]    v_data,
  input  logic [LANES-1:0] v_mask
);

  localparam logic [AW-1:0] LIMIT = AW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic w_in, v_in;

  assign w_in = w_addr < LIMIT;
  assign v_in = v_addr < LIMIT;

  // Combined port is applied after the write port, so it wins overlapping lanes.
  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (w_ok && w_in && w_mask[l])
        mem[w_addr][l*LANE_W +: LANE_W] <= w_data[l*LANE_W +: LANE_W];
      if (v_ok && v_in && v_mask[l])
        mem[v_addr][l*LANE_W +: LANE_W] <= v_data[l*LANE_W +: LANE_W];
    end
  end

  assign ra_data = (ra_en && ra_addr < LIMIT) ? mem[ra_addr] : '0;
  assign rb_data = (rb_en && rb_addr < LIMIT) ? mem[rb_addr] : '0;

  for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
    // R3
    lane_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (w_ok && w_in && !w_mask[l] && !(v_ok && v_in && v_addr == w_addr))
      |=> mem[$past(w_addr)][l*LANE_W +: LANE_W] == $past(mem[w_addr][l*LANE_W +: LANE_W]));
    // R9
    rw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (w_ok && w_in && v_ok && v_in && v_addr == w_addr && w_mask[l] && v_mask[l])
      |=> mem[$past(v_addr)][l*LANE_W +: LANE_W] == $past(v_data[l*LANE_W +: LANE_W]));
  end

endmodule

// File: rtl/masked_mem_ports.sv
module masked_mem_ports #(
  parameter int               DEPTH         = 12,
  parameter int               LANES         = 4,
  parameter int               LANE_W        = 8,
  parameter int               READ_LATENCY  = 2,
  parameter int               WRITE_LATENCY = 2,
  parameter mport_pkg::ruw_e  RUW           = mport_pkg::RUW_NEW,
  parameter bit               USE_RW        = 1'b1,
  localparam int              AW            = $clog2(DEPTH + 1),
  localparam int              DW            = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_data,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [LANES-1:0] wr_mask,
  input  logic             rw_en,
  input  logic [AW-1:0]    rw_addr,
  input  logic             rw_write,
  input  logic [DW-1:0]    rw_wdata,
  input  logic [LANES-1:0] rw_mask,
  output logic [DW-1:0]    rw_rdata
);

  localparam int RC      = mport_pkg::sample_stage(RUW, READ_LATENCY);
  localparam int RD_TAIL = READ_LATENCY - RC;
  localparam int RWL     = READ_LATENCY;
  localparam int WPW     = 1 + AW + DW + LANES;
  localparam int VPW     = 2 + AW + DW + LANES;

  if (WRITE_LATENCY < 1) begin : g_bad_wl
    $error("write latency must be at least one cycle");
  end
  if (USE_RW && (READ_LATENCY != WRITE_LATENCY || RUW == mport_pkg::RUW_OLD)) begin : g_bad_rw
    $error("combined port needs equal latencies and a policy other than old-data");
  end

  // Read-only port: request travels RC stages, data travels the rest.
  logic [AW:0]   rq_s;
  logic [DW-1:0] ra_data;
  mport_delay #(.W(AW + 1), .N(RC)) u_rd_req (
    .clk(clk), .rst_n(rst_n), .din({rd_en, rd_addr}), .dout(rq_s));
  mport_delay #(.W(DW), .N(RD_TAIL)) u_rd_dat (
    .clk(clk), .rst_n(rst_n), .din(ra_data), .dout(rd_data));

  // Write-only port pipeline.
  logic [WPW-1:0]   wq_s;
  logic             wq_en;
  logic [AW-1:0]    wq_addr;
  logic [DW-1:0]    wq_data;
  logic [LANES-1:0] wq_mask;
  mport_delay #(.W(WPW), .N(WRITE_LATENCY)) u_wr (
    .clk(clk), .rst_n(rst_n), .din({wr_en, wr_addr, wr_data, wr_mask}), .dout(wq_s));
  assign {wq_en, wq_addr, wq_data, wq_mask} = wq_s;

  // Combined port pipeline; read and write both act at the last position.
  logic [VPW-1:0]   vq_s;
  logic             vq_en, vq_mode;
  logic [AW-1:0]    vq_addr;
  logic [DW-1:0]    vq_data;
  logic [LANES-1:0] vq_mask;
  logic             vq_rd, vq_wr;
  mport_delay #(.W(VPW), .N(RWL)) u_rw (
    .clk(clk), .rst_n(rst_n),
    .din({rw_en, rw_write, rw_addr, rw_wdata, rw_mask}), .dout(vq_s));
  assign {vq_en, vq_mode, vq_addr, vq_data, vq_mask} = vq_s;
  assign vq_rd = USE_RW && vq_en && !vq_mode;
  assign vq_wr = USE_RW && vq_en && vq_mode;

  mport_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W), .AW(AW)) u_arr (
    .clk(clk), .rst_n(rst_n),
    .ra_en(rq_s[AW]), .ra_addr(rq_s[AW-1:0]), .ra_data(ra_data),
    .rb_en(vq_rd), .rb_addr(vq_addr), .rb_data(rw_rdata),
    .w_ok(wq_en), .w_addr(wq_addr), .w_data(wq_data), .w_mask(wq_mask),
    .v_ok(vq_wr), .v_addr(vq_addr), .v_data(vq_data), .v_mask(vq_mask));

  if (READ_LATENCY > 0) begin : g_rst_chk
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (rd_data == '0 && rw_rdata == '0));
  end

  // R6
  rw_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vq_en && vq_mode) |-> rw_rdata == '0);

endmodule

// File: tb/sim_masked_mem_ports.sv
`timescale 1ns/1ps
module sim_masked_mem_ports;
  localparam int DEPTH = 12, LANES = 4, LANE_W = 8, LAT = 2;
  localparam int DW = LANES * LANE_W, AW = 4, RING = 16, DIR = 16;
  localparam int TOTAL = DIR + 22 + 600;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic rd_en, wr_en, rw_en, rw_write;
  logic [AW-1:0] rd_addr, wr_addr, rw_addr;
  logic [DW-1:0] wr_data, rw_wdata;
  logic [LANES-1:0] wr_mask, rw_mask;
  logic [DW-1:0] rd0, rw0, rd1, rw1, rd2, rw2;

  masked_mem_ports #(.RUW(mport_pkg::RUW_NEW), .USE_RW(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd0),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_mask(wr_mask),
    .rw_en(rw_en), .rw_addr(rw_addr), .rw_write(rw_write), .rw_wdata(rw_wdata),
    .rw_mask(rw_mask), .rw_rdata(rw0));
  masked_mem_ports #(.RUW(mport_pkg::RUW_OLD), .USE_RW(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd1),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_mask(wr_mask),
    .rw_en(rw_en), .rw_addr(rw_addr), .rw_write(rw_write), .rw_wdata(rw_wdata),
    .rw_mask(rw_mask), .rw_rdata(rw1));
  masked_mem_ports #(.RUW(mport_pkg::RUW_UNDEF), .USE_RW(1'b1)) u2 (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd2),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_mask(wr_mask),
    .rw_en(rw_en), .rw_addr(rw_addr), .rw_write(rw_write), .rw_wdata(rw_wdata),
    .rw_mask(rw_mask), .rw_rdata(rw2));

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // Per-cycle request logs and reference arrays (A: with combined port, B: without).
  logic l_rd_en [RING], l_wr_en [RING], l_rw_en [RING], l_rw_wr [RING];
  logic [AW-1:0] l_rd_addr [RING], l_wr_addr [RING], l_rw_addr [RING];
  logic [DW-1:0] l_wr_data [RING], l_rw_data [RING];
  logic [LANES-1:0] l_wr_mask [RING], l_rw_mask [RING];
  string l_tag [RING], l_rwtag [RING];
  logic [DW-1:0] refA [DEPTH], refB [DEPTH];
  logic [DW-1:0] histA [RING][DEPTH], histB [RING][DEPTH];

  function automatic logic [DW-1:0] merge(logic [DW-1:0] o, logic [DW-1:0] n,
                                          logic [LANES-1:0] m);
    for (int l = 0; l < LANES; l++)
      if (m[l]) o[l*LANE_W +: LANE_W] = n[l*LANE_W +: LANE_W];
    return o;
  endfunction

  function automatic logic [DW-1:0] exp_rd(bit use_a, int n, int s);
    int a;
    if (n < 0) return '0;
    if (!l_rd_en[n%RING]) return '0;
    a = int'(l_rd_addr[n%RING]);
    if (a >= DEPTH) return '0;
    return use_a ? histA[(n+s)%RING][a] : histB[(n+s)%RING][a];
  endfunction

  function automatic logic [DW-1:0] exp_rw(int n, int c);
    int a;
    if (n < 0) return '0;
    if (!l_rw_en[n%RING] || l_rw_wr[n%RING]) return '0;
    a = int'(l_rw_addr[n%RING]);
    if (a >= DEPTH) return '0;
    return histA[c%RING][a];
  endfunction

  task automatic check(string tag, string who, int c, logic [DW-1:0] got, logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s cycle %0d got %h expected %h", tag, who, c, got, exp);
    end
  endtask

  // Edge that ends cycle n+LAT commits the writes requested in cycle n.
  task automatic apply_edge(int n);
    int i, a;
    if (n < 0) return;
    i = n % RING;
    if (l_wr_en[i] && int'(l_wr_addr[i]) < DEPTH) begin
      a = int'(l_wr_addr[i]);
      refA[a] = merge(refA[a], l_wr_data[i], l_wr_mask[i]);
      refB[a] = merge(refB[a], l_wr_data[i], l_wr_mask[i]);
    end
    if (l_rw_en[i] && l_rw_wr[i] && int'(l_rw_addr[i]) < DEPTH) begin
      a = int'(l_rw_addr[i]);
      refA[a] = merge(refA[a], l_rw_data[i], l_rw_mask[i]);
    end
  endtask

  task automatic set_idle();
    rd_en = 0; rd_addr = '0; wr_en = 0; wr_addr = '0; wr_data = '0; wr_mask = '0;
    rw_en = 0; rw_addr = '0; rw_write = 0; rw_wdata = '0; rw_mask = '0;
  endtask

  task automatic pick(int c, output string t, output string trw);
    int d;
    set_idle();
    t = "R5"; trw = "R6";
    d = c - DIR;
    if (c < DIR) begin
      t = "R2";
      if (c < DEPTH) begin
        wr_en = 1; wr_addr = AW'(c); wr_mask = '1;
        wr_data = 32'hA0B0C0D0 ^ (32'(c) * 32'h01010101);
      end
      if (c >= 3) begin rd_en = 1; rd_addr = AW'(c - 3); end
    end else if (d <= 3) begin
      rd_en = 1; rd_addr = 4'd5;
      if (d == 0) begin wr_en = 1; wr_addr = 4'd5; wr_data = 32'hA5A5A5A5; wr_mask = '1; end
    end else if (d <= 8) begin
      t = "R3"; rd_en = 1; rd_addr = 4'd7;
      if (d == 4) begin wr_en = 1; wr_addr = 4'd7; wr_data = 32'h11223344; wr_mask = 4'b0101; end
    end else if (d <= 13) begin
      t = "R9"; trw = "R9"; rd_en = 1; rd_addr = 4'd2;
      if (d == 9) begin
        wr_en = 1; wr_addr = 4'd2; wr_data = 32'hFFFF0000; wr_mask = '1;
        rw_en = 1; rw_write = 1; rw_addr = 4'd2; rw_wdata = 32'h12345678; rw_mask = 4'b0110;
      end else begin
        rw_en = 1; rw_addr = 4'd2;
      end
    end else if (d <= 17) begin
      t = "R8"; trw = "R8";
      if (d == 14) begin
        wr_en = 1; wr_addr = 4'd13; wr_data = 32'hDEADBEEF; wr_mask = '1;
        rw_en = 1; rw_write = 1; rw_addr = 4'd14; rw_wdata = 32'h55AA55AA; rw_mask = '1;
        rd_en = 1; rd_addr = 4'd13;
      end else begin
        rd_en = 1; rd_addr = 4'd14; rw_en = 1; rw_addr = 4'd15;
      end
    end else if (d <= 20) begin
      t = "R7"; trw = "R7"; rd_en = 1; rd_addr = 4'd9; rw_en = 1; rw_addr = 4'd9;
      if (d == 18) begin rw_write = 1; rw_wdata = 32'hCAFEBABE; rw_mask = '1; end
    end else if (d == 21) begin
      t = "R4"; rw_addr = 4'd9; rd_addr = 4'd9;
    end else begin
      rd_en = ($urandom % 4) != 0;
      rd_addr = AW'($urandom % 16);
      wr_en = $urandom % 2;
      wr_addr = ($urandom % 2) != 0 ? rd_addr : AW'($urandom % 16);
      wr_data = $urandom; wr_mask = LANES'($urandom % 16);
      rw_en = $urandom % 2; rw_write = $urandom % 2;
      rw_addr = ($urandom % 2) != 0 ? wr_addr : AW'($urandom % 16);
      rw_wdata = $urandom; rw_mask = LANES'($urandom % 16);
      t = rd_en ? "R5" : "R4";
    end
  endtask

  initial begin
    int seed;
    string t, trw, tr, tr1;
    int n, i;
    seed = $urandom(32'd7741);
    set_idle();
    for (int k = 0; k < RING; k++) begin
      l_rd_en[k] = 0; l_wr_en[k] = 0; l_rw_en[k] = 0; l_rw_wr[k] = 0;
      l_rd_addr[k] = '0; l_wr_addr[k] = '0; l_rw_addr[k] = '0;
      l_wr_data[k] = '0; l_rw_data[k] = '0; l_wr_mask[k] = '0; l_rw_mask[k] = '0;
      l_tag[k] = "R5"; l_rwtag[k] = "R6";
    end
    for (int k = 0; k < DEPTH; k++) begin refA[k] = '0; refB[k] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs during reset
    check("R1", "u0 rd", -1, rd0, '0); check("R1", "u0 rw", -1, rw0, '0);
    check("R1", "u1 rd", -1, rd1, '0); check("R1", "u2 rd", -1, rd2, '0);
    rst_n = 1'b1;
    for (int c = 0; c < TOTAL; c++) begin
      if (c > 0) @(negedge clk);
      apply_edge(c - 1 - LAT);
      for (int k = 0; k < DEPTH; k++) begin
        histA[c%RING][k] = refA[k]; histB[c%RING][k] = refB[k];
      end
      n = c - LAT;
      tr = (n < 0) ? "R1" : l_tag[n%RING];
      tr1 = (tr == "R7" || tr == "R9") ? "R10" : tr;
      // R4 R5: new-data samples at +2, old at +0, undefined at +1
      check(tr,  "u0 rd", c, rd0, exp_rd(1'b1, n, 2));
      check(tr1, "u1 rd", c, rd1, exp_rd(1'b0, n, 0));
      check(tr,  "u2 rd", c, rd2, exp_rd(1'b1, n, 1));
      trw = (n < 0) ? "R1" : l_rwtag[n%RING];
      // R6 R7: combined-port read data
      check(trw, "u0 rw", c, rw0, exp_rw(n, c));
      check(trw, "u2 rw", c, rw2, exp_rw(n, c));
      // R10: omitted combined port stays silent
      check("R10", "u1 rw", c, rw1, '0);
      pick(c, t, trw);
      i = c % RING;
      l_rd_en[i] = rd_en; l_rd_addr[i] = rd_addr;
      l_wr_en[i] = wr_en; l_wr_addr[i] = wr_addr; l_wr_data[i] = wr_data; l_wr_mask[i] = wr_mask;
      l_rw_en[i] = rw_en; l_rw_wr[i] = rw_write; l_rw_addr[i] = rw_addr;
      l_rw_data[i] = rw_wdata; l_rw_mask[i] = rw_mask;
      l_tag[i] = t; l_rwtag[i] = trw;
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1 watchdog got running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule